// File: doc/BRIEF.md
# Credit Transmit Gate

This block sits on the transmit side of a serial link and decides, one packet at a time, whether the far receiver still has buffer room for it. The receiver announces its buffer size as a number of credits once the link comes up, and later hands credits back as it drains its buffer. The gate keeps two free-running wrapping counters: the total credits spent since reset and the total credits granted since reset (the credit limit). A packet is let through when its cost still fits below the limit.

A requester presents a packet's cost with a valid strobe. The gate raises ready in the same cycle when the cost fits, so a stream of packets moves at one per cycle for as long as credit lasts, and the delay of credit returns only matters once the limit is reached. Because both counters wrap, the fit test uses a modular difference and reads its sign bit. It does not compare the two magnitudes.

Top module: `credit_tx_gate`

## Requirements
- R1: After reset, `req_ready_o` stays low until the first cycle that follows a cycle with `init_valid_i` high, whatever the request inputs do.
- R2: The first `init_valid_i` after reset loads `init_credit_i` as the credit limit, with the spent count at zero. Any later `init_valid_i` is ignored until the next reset.
- R3: Once loaded, `req_ready_o` is high exactly when `req_valid_i` is high and (limit − (spent + cost)) mod 4096 is below 2048. An exact fit (result 0) passes, and a cost of 0 passes whenever the gate is open.
- R4: On a clock edge where `req_valid_i` and `req_ready_o` are both high, the spent count grows by the effective cost. On any other edge it stays unchanged.
- R5: A cycle with `ret_valid_i` high adds `ret_credit_i` to the limit. The new limit affects `req_ready_o` only from the next cycle on. A return and an acceptance in the same cycle both take effect. The user keeps limit minus spent below 2048.
- R6: Consecutive requests that each fit are accepted in consecutive cycles, with no idle cycle inserted between them.
- R7: Both counters wrap modulo 4096, and the fit test of R3 gives the correct result when either counter has wrapped past the other.
- R8: A request cost above 2047 is treated as a cost of 2047, both in the fit test and in the amount added to the spent count.
- R9: Asserting `rst_ni` low clears the spent count and closes the gate, so a new advertisement starts from a clean account.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_valid_i | input | 1 | Initial credit advertisement strobe |
| init_credit_i | input | CNT_W-1 | Initial credit amount |
| req_valid_i | input | 1 | Packet request valid |
| req_cost_i | input | COST_W | Credit cost of the requested packet |
| req_ready_o | output | 1 | Packet may be sent this cycle |
| ret_valid_i | input | 1 | Credit return strobe |
| ret_credit_i | input | CNT_W-1 | Amount of credit returned |

## Verification
The bench uses the default counter width of 12 and a cost input that is also 12 bits wide. The cost input is therefore wider than the half-range clamp, and costs such as 4095 can exercise the clamp of R8. With 12-bit counters, steps of 2000 credits carry the limit past 4096 in three returns. This reaches the state where the limit has wrapped but the spent count has not, and a magnitude compare would give the wrong answer there. Exact-fit and one-over costs are applied on both sides of that wrap.

// File: rtl/credit_gate_pkg.sv
package credit_gate_pkg;
  typedef enum logic {
    GATE_WAIT_ADV = 1'b0,
    GATE_OPEN     = 1'b1
  } gate_state_e;
endpackage

// File: rtl/cg_cost_clamp.sv
module cg_cost_clamp #(
  parameter int unsigned COST_W = 12,
  parameter int unsigned CNT_W  = 12
) (
  input  logic [COST_W-1:0] cost_i,
  output logic [CNT_W-1:0]  cost_o
);
  localparam int unsigned HALF_W = CNT_W - 1;

  generate
    if (COST_W > HALF_W) begin : g_clamp
      localparam int unsigned XW = COST_W - HALF_W;
      logic over;
      assign over   = |cost_i[COST_W-1:HALF_W];
      assign cost_o = over ? {1'b0, {HALF_W{1'b1}}}
                           : {1'b0, cost_i[HALF_W-1:0]};
    end else begin : g_pass
      assign cost_o = {{(CNT_W-COST_W){1'b0}}, cost_i};
    end
  endgenerate
endmodule

// File: rtl/cg_wrap_acc.sv
module cg_wrap_acc #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         add_i,
  input  logic [W-1:0] add_val_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_q <= '0;
    else if (load_i) value_q <= load_val_i;
    else if (add_i)  value_q <= value_q + add_val_i; // wraps mod 2^W
  end

  assign value_o = value_q;
endmodule

// File: rtl/cg_window_check.sv
module cg_window_check #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] limit_i,
  input  logic [W-1:0] spent_i,
  input  logic [W-1:0] cost_i,
  output logic         fits_o
);
  logic [W-1:0] after_spend;
  logic [W-1:0] headroom;

  assign after_spend = spent_i + cost_i;
  assign headroom    = limit_i - after_spend;
  // sign bit of the modular difference: set means past the limit
  assign fits_o      = ~headroom[W-1];
endmodule

// File: rtl/credit_tx_gate.sv
module credit_tx_gate
  import credit_gate_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned COST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_valid_i,
  input  logic [CNT_W-2:0]  init_credit_i,
  input  logic              req_valid_i,
  input  logic [COST_W-1:0] req_cost_i,
  output logic              req_ready_o,
  input  logic              ret_valid_i,
  input  logic [CNT_W-2:0]  ret_credit_i
);
  gate_state_e state_q;
  logic        gate_open;
  logic        adv_load;
  logic        accept;
  logic        fits;
  logic [CNT_W-1:0] cost_eff;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] spent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     state_q <= GATE_WAIT_ADV;
    else if (state_q == GATE_WAIT_ADV && init_valid_i) state_q <= GATE_OPEN;
  end

  assign gate_open = (state_q == GATE_OPEN);
  assign adv_load  = (state_q == GATE_WAIT_ADV) && init_valid_i;

  cg_cost_clamp #(.COST_W(COST_W), .CNT_W(CNT_W)) u_clamp (
    .cost_i (req_cost_i),
    .cost_o (cost_eff)
  );

  cg_wrap_acc #(.W(CNT_W)) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (adv_load),
    .load_val_i ({1'b0, init_credit_i}),
    .add_i      (gate_open && ret_valid_i),
    .add_val_i  ({1'b0, ret_credit_i}),
    .value_o    (limit_q)
  );

  cg_wrap_acc #(.W(CNT_W)) u_spent (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (1'b0),
    .load_val_i ('0),
    .add_i      (accept),
    .add_val_i  (cost_eff),
    .value_o    (spent_q)
  );

  cg_window_check #(.W(CNT_W)) u_check (
    .limit_i (limit_q),
    .spent_i (spent_q),
    .cost_i  (cost_eff),
    .fits_o  (fits)
  );

  assign req_ready_o = gate_open && req_valid_i && fits;
  assign accept      = req_valid_i && req_ready_o;
endmodule

// File: rtl/credit_tx_gate_chk.sv
module credit_tx_gate_chk #(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned COST_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_valid_i,
  input logic              req_valid_i,
  input logic [COST_W-1:0] req_cost_i,
  input logic              req_ready_o,
  input logic              ret_valid_i,
  input logic [CNT_W-2:0]  ret_credit_i,
  input logic              gate_open,
  input logic [CNT_W-1:0]  cost_eff,
  input logic [CNT_W-1:0]  limit_q,
  input logic [CNT_W-1:0]  spent_q
);
  logic seen_adv_q;
  logic [CNT_W-1:0] slack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           seen_adv_q <= 1'b0;
    else if (init_valid_i) seen_adv_q <= 1'b1;
  end

  assign slack = limit_q - spent_q;

  // R1
  closed_before_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_adv_q |-> !req_ready_o);

  // R3
  ready_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i);

  // R4
  spend_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> spent_q == $past(spent_q + cost_eff));

  // R4
  spend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(spent_q));

  // R5
  limit_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_open && ret_valid_i) |=> limit_q == $past(limit_q + {1'b0, ret_credit_i}));

  // R2
  readv_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_open && init_valid_i && !ret_valid_i) |=> $stable(limit_q));

  // R7
  no_overdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_open |-> !slack[CNT_W-1]);

  // R8
  cost_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !cost_eff[CNT_W-1]);
endmodule

bind credit_tx_gate credit_tx_gate_chk #(.CNT_W(CNT_W), .COST_W(COST_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_valid_i (init_valid_i),
  .req_valid_i  (req_valid_i),
  .req_cost_i   (req_cost_i),
  .req_ready_o  (req_ready_o),
  .ret_valid_i  (ret_valid_i),
  .ret_credit_i (ret_credit_i),
  .gate_open    (gate_open),
  .cost_eff     (cost_eff),
  .limit_q      (limit_q),
  .spent_q      (spent_q)
);

// File: tb/credit_tx_gate_tb_top.sv
`timescale 1ns/1ps
module credit_tx_gate_tb_top;
  localparam int CNT_W  = 12;
  localparam int COST_W = 12;
  localparam int NROWS  = 25;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              init_valid_i = 1'b0;
  logic [CNT_W-2:0]  init_credit_i = '0;
  logic              req_valid_i = 1'b0;
  logic [COST_W-1:0] req_cost_i = '0;
  logic              req_ready_o;
  logic              ret_valid_i = 1'b0;
  logic [CNT_W-2:0]  ret_credit_i = '0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  credit_tx_gate #(.CNT_W(CNT_W), .COST_W(COST_W)) dut_i (
    .clk_i, .rst_ni, .init_valid_i, .init_credit_i,
    .req_valid_i, .req_cost_i, .req_ready_o, .ret_valid_i, .ret_credit_i
  );

  // {init_v, init_val[10:0], req_v, cost[11:0], ret_v, ret[10:0], exp_ready}
  localparam logic [37:0] VEC [NROWS] = '{
    {1'b0, 11'd0,   1'b1, 12'd4,    1'b0, 11'd0,    1'b1}, // R3 R6 spent 4
    {1'b0, 11'd0,   1'b1, 12'd4,    1'b0, 11'd0,    1'b1}, // R6 spent 8
    {1'b0, 11'd0,   1'b1, 12'd3,    1'b0, 11'd0,    1'b0}, // R3 one over
    {1'b0, 11'd0,   1'b1, 12'd2,    1'b0, 11'd0,    1'b1}, // R3 exact fit
    {1'b0, 11'd0,   1'b1, 12'd1,    1'b1, 11'd5,    1'b0}, // R5 return not yet seen
    {1'b0, 11'd0,   1'b1, 12'd1,    1'b0, 11'd0,    1'b1}, // R5 return now seen
    {1'b0, 11'd0,   1'b0, 12'd1,    1'b0, 11'd0,    1'b0}, // R3 no valid
    {1'b0, 11'd0,   1'b1, 12'd0,    1'b0, 11'd0,    1'b1}, // R3 zero cost
    {1'b0, 11'd0,   1'b0, 12'd0,    1'b1, 11'd2000, 1'b0}, // R5
    {1'b0, 11'd0,   1'b1, 12'd2000, 1'b0, 11'd0,    1'b1}, // R4
    {1'b0, 11'd0,   1'b0, 12'd0,    1'b1, 11'd2000, 1'b0}, // R5
    {1'b0, 11'd0,   1'b1, 12'd2000, 1'b0, 11'd0,    1'b1}, // R4
    {1'b0, 11'd0,   1'b0, 12'd0,    1'b1, 11'd2000, 1'b0}, // R7 limit wraps
    {1'b0, 11'd0,   1'b1, 12'd5,    1'b0, 11'd0,    1'b1}, // R7
    {1'b0, 11'd0,   1'b1, 12'd2000, 1'b0, 11'd0,    1'b0}, // R7 one over
    {1'b0, 11'd0,   1'b1, 12'd1999, 1'b0, 11'd0,    1'b1}, // R7 exact, spent wraps
    {1'b0, 11'd0,   1'b1, 12'd1,    1'b0, 11'd0,    1'b0}, // R7
    {1'b0, 11'd0,   1'b0, 12'd0,    1'b1, 11'd2047, 1'b0}, // R5
    {1'b0, 11'd0,   1'b1, 12'd4095, 1'b0, 11'd0,    1'b1}, // R8 clamped to 2047
    {1'b0, 11'd0,   1'b1, 12'd1,    1'b0, 11'd0,    1'b0}, // R8 2047 was spent
    {1'b1, 11'd500, 1'b1, 12'd1,    1'b0, 11'd0,    1'b0}, // R2 re-advertise
    {1'b0, 11'd0,   1'b1, 12'd1,    1'b0, 11'd0,    1'b0}, // R2 ignored
    {1'b0, 11'd0,   1'b0, 12'd0,    1'b1, 11'd3,    1'b0}, // R5
    {1'b0, 11'd0,   1'b1, 12'd3,    1'b0, 11'd0,    1'b1}, // R4 exact
    {1'b0, 11'd0,   1'b1, 12'd0,    1'b0, 11'd0,    1'b1}  // R3 zero cost at limit
  };

  function automatic string row_tag(int i);
    if (i <= 7)  return "R3/R6";
    if (i <= 11) return "R4/R5";
    if (i <= 16) return "R7";
    if (i <= 19) return "R8";
    if (i <= 21) return "R2";
    return "R5/R4";
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s ready=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [CNT_W-2:0] ival,
                       input logic v, input logic [COST_W-1:0] cost,
                       input logic rv, input logic [CNT_W-2:0] ret);
    @(negedge clk_i);
    init_valid_i  = iv;
    init_credit_i = ival;
    req_valid_i   = v;
    req_cost_i    = cost;
    ret_valid_i   = rv;
    ret_credit_i  = ret;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 during reset
    req_valid_i = 1'b1;
    req_cost_i  = 12'd1;
    #1;
    check("R1 in reset", req_ready_o, 1'b0);
    #10;
    drive(1'b0, '0, 1'b1, 12'd1, 1'b0, '0);
    rst_ni = 1'b1;
    #1;
    check("R1 before adv", req_ready_o, 1'b0);
    drive(1'b1, 11'd10, 1'b1, 12'd1, 1'b0, '0);
    check("R1 adv cycle", req_ready_o, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      logic [37:0] r;
      r = VEC[i];
      drive(r[37], r[36:26], r[25], r[24:13], r[12], r[11:1]);
      check($sformatf("%s row %0d", row_tag(i), i), req_ready_o, r[0]);
    end

    // R9 reset mid-run, then a fresh account
    drive(1'b0, '0, 1'b1, 12'd1, 1'b0, '0);
    rst_ni = 1'b0;
    #1;
    check("R9 reset closes", req_ready_o, 1'b0);
    drive(1'b0, '0, 1'b1, 12'd1, 1'b0, '0);
    rst_ni = 1'b1;
    drive(1'b1, 11'd3, 1'b0, '0, 1'b0, '0);
    drive(1'b0, '0, 1'b1, 12'd3, 1'b0, '0);
    check("R9 spent cleared", req_ready_o, 1'b1);
    drive(1'b0, '0, 1'b1, 12'd1, 1'b0, '0);
    check("R9 new limit reached", req_ready_o, 1'b0);
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule